// File: doc/BRIEF.md
# Sector Buffer Load Sequencer

This block is the device-side control for a memory that is programmed one 256-byte sector at a time. It watches the parallel bus control lines (chip enable, write enable, output enable) for byte-load strobes and passes each accepted byte to a sector buffer as a single-cycle write. The byte offset and the data come from the bus.

The first load, taken while the unlock flag from the command detector is high, opens a load phase and fixes the sector. Later loads may hit any offset of that sector in any order. Each accepted load restarts an inactivity window. When no load begins inside that window, the block pulses a commit and runs a fixed-length programming period with busy high.

A write attempted while the unlock flag is low stores nothing and raises no commit. It still runs the busy period, so that status polling behaves the same as for a real program cycle.

Top module: `sector_load_seq`

## Requirements
- R1: A byte load is the interval in which ce_ni and we_ni are both low while oe_ni is high. The load completes on the first clock edge at which that condition no longer holds. With oe_ni low, no load takes place.
- R2: The address is sampled at the first clock edge of a load. The data is the value present at the last edge of the load. An accepted load drives buf_we_o high for exactly the one cycle after the completing edge, with buf_addr_o = address bits 7:0 and buf_data_o = that data.
- R3: An unlocked first load, taken while no phase is open, opens a load phase and sets prog_sector_o to its address bits 17:8. prog_sector_o then holds for the whole phase and the programming period that follows.
- R4: Within a load phase, loads to any offsets of the open sector are accepted in any order, each producing its own buffer write.
- R5: A load in the load phase whose bits 17:8 differ from the open sector writes nothing. Instead it pulses sector_err_o for one cycle, timed as buf_we_o would have been, and it does not restart the inactivity window.
- R6: commit_o pulses for one cycle exactly TIMEOUT_CYC cycles after the buffer-write cycle of the last accepted load, unless a load to the open sector begins at or before that edge. A load starting TIMEOUT_CYC-1 cycles after the write cycle keeps the phase open. One starting TIMEOUT_CYC cycles after it arrives too late.
- R7: busy_o rises in the cycle of commit_o and stays high for exactly PROG_CYC cycles.
- R8: Loads that complete while busy_o is high produce no buffer write, no error and no commit, and they do not change the length of the busy period.
- R9: A first load taken while unlocked_i is low produces no buffer write and no commit. busy_o rises in the cycle after the completing edge and stays high for PROG_CYC cycles.
- R10: After reset, busy_o, commit_o, buf_we_o and sector_err_o are low and prog_sector_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 18 | Bus address: 17:8 sector, 7:0 offset |
| data_i | input | 8 | Bus data |
| unlocked_i | input | 1 | Unlock sequence seen by the command detector |
| busy_o | output | 1 | Programming period running |
| prog_sector_o | output | 10 | Sector of the current load phase |
| buf_we_o | output | 1 | Sector buffer write strobe |
| buf_addr_o | output | 8 | Sector buffer offset |
| buf_data_o | output | 8 | Sector buffer data |
| commit_o | output | 1 | Start of array programming, one cycle |
| sector_err_o | output | 1 | Load to a foreign sector rejected, one cycle |

## Verification
The hardest situations to reach are at the edge of the inactivity window. One is a load that begins exactly on the last edge at which it still extends the phase. The other is a load one cycle later, which must fall into the busy period and vanish. The stimulus spaces loads by counted idle cycles after each completing edge, so both boundary gaps are hit exactly. A foreign-sector load is placed late in a phase to show that it does not extend the window. A chip-enable-controlled load changes the address and the data mid-strobe to confirm which edge samples each.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } sls_state_e;
endpackage

// File: rtl/sls_strobe_dec.sv
module sls_strobe_dec #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              active_o,
  output logic              fire_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [ADDR_W-1:0] live_addr_o,
  output logic [DATA_W-1:0] cap_data_o
);
  logic              act, act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign act = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) addr_q <= addr_i;   // last falling control edge
      if (act) data_q <= data_i;             // value held until first rising edge
    end
  end

  assign active_o    = act;
  assign fire_o      = act_q & ~act;
  assign cap_addr_o  = addr_q;
  assign cap_data_o  = data_q;
  assign live_addr_o = (act && !act_q) ? addr_i : addr_q;
endmodule

// File: rtl/sls_timer.sv
module sls_timer #(
  parameter int LIMIT = 7500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || clr_i)  cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i & ~clr_i & (cnt_q == LAST);
endmodule

// File: rtl/sector_load_seq.sv
module sector_load_seq #(
  parameter int ADDR_W      = 18,
  parameter int OFF_W       = 8,
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 7500,
  parameter int PROG_CYC    = 500000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ce_ni,
  input  logic                      we_ni,
  input  logic                      oe_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic                      unlocked_i,
  output logic                      busy_o,
  output logic [ADDR_W-OFF_W-1:0]   prog_sector_o,
  output logic                      buf_we_o,
  output logic [OFF_W-1:0]          buf_addr_o,
  output logic [DATA_W-1:0]         buf_data_o,
  output logic                      commit_o,
  output logic                      sector_err_o
);
  import sls_pkg::*;

  localparam int SECT_W = ADDR_W - OFF_W;

  logic              active, fire;
  logic [ADDR_W-1:0] cap_addr, live_addr;
  logic [DATA_W-1:0] cap_data;
  logic [SECT_W-1:0] cap_sect, live_sect;
  logic              same_sect, fire_ok, rearm;
  logic              to_expire, pg_expire;

  sls_state_e        state_q;
  logic [SECT_W-1:0] sect_q;
  logic              we_q, err_q, commit_q;
  logic [OFF_W-1:0]  baddr_q;
  logic [DATA_W-1:0] bdata_q;

  sls_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .we_ni       (we_ni),
    .oe_ni       (oe_ni),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .active_o    (active),
    .fire_o      (fire),
    .cap_addr_o  (cap_addr),
    .live_addr_o (live_addr),
    .cap_data_o  (cap_data)
  );

  assign cap_sect  = cap_addr[ADDR_W-1:OFF_W];
  assign live_sect = live_addr[ADDR_W-1:OFF_W];
  assign same_sect = (cap_sect == sect_q);
  assign fire_ok   = fire & same_sect;
  // a strobe into the open sector holds the window while it lasts
  assign rearm     = fire_ok | (active & (live_sect == sect_q));

  sls_timer #(.LIMIT(TIMEOUT_CYC)) u_idle_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_LOAD),
    .clr_i    (rearm),
    .expire_o (to_expire)
  );

  sls_timer #(.LIMIT(PROG_CYC)) u_prog_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_PROG),
    .clr_i    (1'b0),
    .expire_o (pg_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sect_q   <= '0;
      we_q     <= 1'b0;
      err_q    <= 1'b0;
      commit_q <= 1'b0;
      baddr_q  <= '0;
      bdata_q  <= '0;
    end else begin
      we_q     <= 1'b0;
      err_q    <= 1'b0;
      commit_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            if (unlocked_i) begin
              sect_q  <= cap_sect;
              we_q    <= 1'b1;
              baddr_q <= cap_addr[OFF_W-1:0];
              bdata_q <= cap_data;
              state_q <= ST_LOAD;
            end else begin
              state_q <= ST_PROG;   // timer runs, nothing stored
            end
          end
        end
        ST_LOAD: begin
          if (to_expire) begin
            commit_q <= 1'b1;
            state_q  <= ST_PROG;
          end else if (fire) begin
            if (same_sect) begin
              we_q    <= 1'b1;
              baddr_q <= cap_addr[OFF_W-1:0];
              bdata_q <= cap_data;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (pg_expire) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q == ST_PROG);
  assign prog_sector_o = sect_q;
  assign buf_we_o      = we_q;
  assign buf_addr_o    = baddr_q;
  assign buf_data_o    = bdata_q;
  assign commit_o      = commit_q;
  assign sector_err_o  = err_q;
endmodule

// File: rtl/sls_checker.sv
module sls_checker #(
  parameter int SECT_W   = 10,
  parameter int PROG_CYC = 500000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic              busy_o,
  input logic [SECT_W-1:0] prog_sector_o,
  input logic              buf_we_o,
  input logic              commit_o,
  input logic              sector_err_o
);
  localparam int RUN_W = $clog2(PROG_CYC + 2) + 1;

  logic             strobe;
  logic [RUN_W-1:0] run_q;

  assign strobe = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_we_after_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> ($past(strobe, 2) && !$past(strobe)));

  p_one_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_we_o, sector_err_o, commit_o}));

  p_sector_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(prog_sector_o));

  p_err_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_err_o |=> !sector_err_o);

  p_commit_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  p_commit_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> busy_o);

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == RUN_W'(PROG_CYC)));

  p_quiet_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (!buf_we_o && !sector_err_o));
endmodule

bind sector_load_seq sls_checker #(
  .SECT_W   (ADDR_W - OFF_W),
  .PROG_CYC (PROG_CYC)
) u_sls_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ce_ni         (ce_ni),
  .we_ni         (we_ni),
  .oe_ni         (oe_ni),
  .busy_o        (busy_o),
  .prog_sector_o (prog_sector_o),
  .buf_we_o      (buf_we_o),
  .commit_o      (commit_o),
  .sector_err_o  (sector_err_o)
);

// File: tb/sim_sector_load_seq.sv
module sim_sector_load_seq;
  localparam int T = 20;
  localparam int P = 30;
  localparam int K_WE = 0, K_ERR = 1, K_COMMIT = 2, K_BRISE = 3, K_BFALL = 4;

  typedef struct {
    int    kind;
    int    cyc;
    int    a;
    int    d;
    string req;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, unl = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy, bwe, commit, serr;
  logic [9:0]  psect;
  logic [7:0]  baddr, bdata;

  int   cyc = 0, n_cmp = 0, n_bad = 0;
  bit   done = 1'b0, pb = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sector_load_seq #(.TIMEOUT_CYC(T), .PROG_CYC(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .unlocked_i(unl),
    .busy_o(busy), .prog_sector_o(psect), .buf_we_o(bwe),
    .buf_addr_o(baddr), .buf_data_o(bdata), .commit_o(commit),
    .sector_err_o(serr)
  );

  function automatic void push(int k, int c, int a, int d, string r);
    exp_t e;
    e.kind = k; e.cyc = c; e.a = a; e.d = d; e.req = r;
    q.push_back(e);
  endfunction

  function automatic void got(int k, int a, int d);
    exp_t e;
    n_cmp++;
    if (q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: kind %0d at cycle %0d a=%0h d=%0h, expected none", k, cyc, a, d);
      return;
    end
    e = q.pop_front();
    if (e.kind != k || e.cyc != cyc || e.a != a || e.d != d) begin
      n_bad++;
      $display("FAIL %s: got kind %0d cyc %0d a=%0h d=%0h, expected kind %0d cyc %0d a=%0h d=%0h",
               e.req, k, cyc, a, d, e.kind, e.cyc, e.a, e.d);
    end
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bwe)          got(K_WE, int'(baddr), int'(bdata));
      if (serr)         got(K_ERR, 0, 0);
      if (commit)       got(K_COMMIT, int'(psect), 0);
      if (busy && !pb)  got(K_BRISE, 0, 0);
      if (!busy && pb)  got(K_BFALL, 0, 0);
      pb = busy;
    end
  end

  // WE-controlled load; returns the completing edge number
  task automatic load(input logic [17:0] a, input logic [7:0] d, input int hold, output int n);
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    n = cyc + 1;
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic idle(input int g);
    repeat (g) @(negedge clk);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int n, ng;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;  // R10 reset state
    if (busy || commit || bwe || serr || psect != 0) begin
      n_bad++;
      $display("FAIL R10: busy=%b commit=%b we=%b err=%b sect=%0h, expected all zero",
               busy, commit, bwe, serr, psect);
    end

    // R3 R4: scattered offsets in one sector, R6 boundary gap T-1 keeps phase
    load({10'h155, 8'h10}, 8'hA1, 2, n); push(K_WE, n, 'h10, 'hA1, "R3");
    idle(5);
    load({10'h155, 8'h03}, 8'hB2, 1, n); push(K_WE, n, 'h03, 'hB2, "R4");
    idle(T - 1);
    load({10'h155, 8'hFF}, 8'hC3, 3, n); push(K_WE, n, 'hFF, 'hC3, "R6");
    idle(2);
    load({10'h155, 8'h00}, 8'hD4, 1, ng); push(K_WE, ng, 'h00, 'hD4, "R4");
    idle(3);
    // R5: foreign sector rejected, window not extended
    load({10'h0AA, 8'h44}, 8'h99, 2, n); push(K_ERR, n, 0, 0, "R5");
    push(K_COMMIT, ng + T, 'h155, 0, "R5");
    push(K_BRISE, ng + T, 0, 0, "R7");
    push(K_BFALL, ng + T + P, 0, 0, "R7");
    wait_cyc(ng + T + 3);
    // R8: load during programming ignored
    load({10'h155, 8'h22}, 8'h77, 2, n);
    wait_cyc(ng + T + P + 3);

    // R6: gap of T arrives too late, second load falls in busy (R8)
    load({10'h002, 8'h05}, 8'h5A, 1, n); push(K_WE, n, 'h05, 'h5A, "R6");
    push(K_COMMIT, n + T, 'h002, 0, "R6");
    push(K_BRISE, n + T, 0, 0, "R7");
    push(K_BFALL, n + T + P, 0, 0, "R8");
    ng = n;
    idle(T);
    load({10'h002, 8'h06}, 8'h6B, 1, n);
    wait_cyc(ng + T + P + 3);

    // R9: locked write runs the timer only
    unl = 1'b0;
    load({10'h011, 8'h01}, 8'hEE, 2, n);
    push(K_BRISE, n, 0, 0, "R9");
    push(K_BFALL, n + P, 0, 0, "R9");
    wait_cyc(n + P + 3);
    unl = 1'b1;

    // R1: output enable low blocks the load
    @(negedge clk);
    oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; addr = {10'h3C0, 8'h0F}; data = 8'h12;
    idle(3);
    ce_n = 1'b1; we_n = 1'b1;
    idle(2);
    oe_n = 1'b1;
    idle(T + 5);

    // R1 R2: CE-controlled load; address at last falling edge, data at end
    @(negedge clk);
    addr = {10'h001, 8'h01}; data = 8'h11; we_n = 1'b0;
    @(negedge clk);
    addr = {10'h3FF, 8'h80}; data = 8'h22; ce_n = 1'b0;
    @(negedge clk);
    addr = {10'h001, 8'h02}; data = 8'h5C;
    @(negedge clk);
    n = cyc + 1;
    ce_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    push(K_WE, n, 'h80, 'h5C, "R2");
    push(K_COMMIT, n + T, 'h3FF, 0, "R3");
    push(K_BRISE, n + T, 0, 0, "R7");
    push(K_BFALL, n + T + P, 0, 0, "R7");
    wait_cyc(n + T + P + 3);

    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d expected events never seen, expected 0", q[0].req, q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule